// File: doc/BRIEF.md
# Address-Matching Packet Receive Engine

This block sits behind a demodulator and looks for packets addressed to it in a continuous bit stream. There is no preamble or start marker. Every bit that enters slides a 256-bit window forward by one place. The block then asks whether the most recent P bits form a packet whose first N bits equal the configured own address.

On an address hit the block checks the packet's trailing CRC. It recomputes the CRC serially over the address and payload bits that are still held in the window, and the input stream is stalled while it does so. If the CRC is disabled, the address hit alone is enough. A good packet has its payload copied into an output shift register, with the address and CRC removed, and a data-ready flag rises. A bad packet sends the block straight back to searching.

The host reads the payload one bit at a time at its own pace. It samples the output bit and then raises its own slow readout clock to advance to the next bit. That clock is synchronised inside the block. Bits arrive on a valid/ready stream: a bit is taken on a clock edge where both in_valid and in_ready are high. The source must hold in_bit and in_valid while in_ready is low. in_ready is low only while a CRC check is in progress.

Top module: `addr_match_rx`

## Requirements
- R1: After reset, data_ready, data_out and overflow are 0 and in_ready is 1.
- R2: A bit is taken on each clock edge where in_valid and in_ready are both 1. Stream order is significant: the earliest bit of a packet is the address MSB, and payload and CRC are also sent MSB first.
- R3: The address search is re-evaluated after every accepted bit, so a packet preceded by any number of unrelated bits is found without a preamble.
- R4: With cfg_crc_en=1 and cfg_crc_wide=1, the last 16 packet bits are a CRC with polynomial 0x1021 and initial value 0xFFFF, taken MSB first over address and payload bits. A packet whose CRC agrees is delivered.
- R5: A packet whose address matches but whose CRC disagrees is not delivered, and the search continues, so a valid packet that follows is delivered.
- R6: With cfg_crc_en=1 and cfg_crc_wide=0, the last 8 packet bits are a CRC with polynomial 0x07 and initial value 0xFF, taken MSB first over address and payload bits.
- R7: With cfg_crc_en=0, the packet carries no CRC bits and is delivered on an address match alone.
- R8: On delivery, data_ready rises and data_out shows the first payload bit. Each synchronised rising edge of host_clk advances by one bit. data_ready stays high until the edge that moves past the last payload bit, and then falls. data_out is 0 while data_ready is 0.
- R9: A valid packet that completes while data_ready is high is dropped, and overflow pulses high for one cycle. The held payload is left unchanged.
- R10: cfg_pkt_len counts address, payload and CRC bits. Values above 256 are treated as 256.
- R11: Address lengths from 1 to 40 bits are matched. A packet whose address differs in any bit is not delivered.
- R12: in_ready is low while a CRC check runs, from the edge that accepted the last packet bit, for P minus CRC-length cycles. With the CRC disabled, in_ready stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Demodulated bit is present |
| in_bit | input | 1 | Demodulated bit value |
| in_ready | output | 1 | Engine can take a bit this cycle |
| cfg_own_addr | input | 40 | Own address, right-aligned; bit N-1 is sent first |
| cfg_addr_len | input | 6 | Address length N, 1 to 40 |
| cfg_pkt_len | input | 10 | Packet length P in bits, clamped to 256 |
| cfg_crc_en | input | 1 | Packet carries a CRC |
| cfg_crc_wide | input | 1 | 1 selects the 16-bit CRC, 0 selects the 8-bit CRC |
| host_clk | input | 1 | Host readout clock, asynchronous |
| data_ready | output | 1 | Payload held and not fully read |
| data_out | output | 1 | Current payload bit |
| overflow | output | 1 | One-cycle pulse when a valid packet is dropped |

## Verification
A wrong window alignment or a wrong address-bit order never shows up as a mismatch flag. It shows up as a packet that is never delivered or a payload that is shifted. It becomes visible at data_out on the first readout bit, a few cycles after data_ready would have risen. A wrong CRC state or a wrong step count turns a good packet into a silent drop, or leaves in_ready low for the wrong number of cycles, and the stall length can be checked within P cycles of the last bit. A stale remaining-bit counter shows up as data_ready falling one edge early or late, and a lost hold on the output register shows up as the dropped packet's payload appearing on readout.

// File: rtl/amr_pkg.sv
package amr_pkg;
  typedef enum logic {ST_SEARCH = 1'b0, ST_CHECK = 1'b1} amr_state_e;

  localparam logic [15:0] CRC16_POLY = 16'h1021;
  localparam logic [15:0] CRC16_INIT = 16'hFFFF;
  localparam logic [7:0]  CRC8_POLY  = 8'h07;
  localparam logic [7:0]  CRC8_INIT  = 8'hFF;

  // One serial CRC step, MSB first. In narrow mode the upper byte stays zero.
  function automatic logic [15:0] crc_advance(input logic [15:0] cur, input logic din,
                                              input logic wide);
    logic        fb;
    logic [15:0] res;
    if (wide) begin
      fb  = cur[15] ^ din;
      res = {cur[14:0], 1'b0};
      if (fb) res = res ^ CRC16_POLY;
    end else begin
      fb  = cur[7] ^ din;
      res = {8'h00, cur[6:0], 1'b0};
      if (fb) res = res ^ {8'h00, CRC8_POLY};
    end
    return res;
  endfunction
endpackage

// File: rtl/amr_window.sv
module amr_window #(
  parameter int WIN_BITS = 256,
  localparam int LEN_W = $clog2(WIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                shift_en,
  input  logic                bit_in,
  output logic [WIN_BITS-1:0] win_q,
  output logic [WIN_BITS-1:0] win_nxt,
  output logic [LEN_W-1:0]    fill_nxt
);
  logic [LEN_W-1:0] fill_q;

  assign win_nxt  = {win_q[WIN_BITS-2:0], bit_in};
  assign fill_nxt = (fill_q == LEN_W'(WIN_BITS)) ? fill_q : fill_q + LEN_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (shift_en) begin
      win_q  <= win_nxt;
      fill_q <= fill_nxt;
    end
  end
endmodule

// File: rtl/amr_addr_cmp.sv
module amr_addr_cmp #(
  parameter int WIN_BITS = 256,
  parameter int ADDR_MAX = 40,
  localparam int LEN_W = $clog2(WIN_BITS + 1),
  localparam int AW    = $clog2(ADDR_MAX + 1),
  localparam int IW    = $clog2(WIN_BITS),
  localparam int AIW   = $clog2(ADDR_MAX)
) (
  input  logic [WIN_BITS-1:0] win,
  input  logic [LEN_W-1:0]    pkt_len,
  input  logic [AW-1:0]       addr_len,
  input  logic [ADDR_MAX-1:0] own_addr,
  output logic                hit
);
  always_comb begin
    hit = 1'b1;
    for (int i = 0; i < ADDR_MAX; i++) begin
      if (i < int'(addr_len) && (int'(pkt_len) - 1 - i) >= 0) begin
        if (win[IW'(int'(pkt_len) - 1 - i)] != own_addr[AIW'(int'(addr_len) - 1 - i)])
          hit = 1'b0;
      end
    end
  end
endmodule

// File: rtl/amr_crc_unit.sv
module amr_crc_unit
  import amr_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        init,
  input  logic        step,
  input  logic        bit_in,
  input  logic        wide,
  output logic [15:0] crc_nxt
);
  logic [15:0] crc_q;

  assign crc_nxt = crc_advance(crc_q, bit_in, wide);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    crc_q <= '0;
    else if (init) crc_q <= wide ? CRC16_INIT : {8'h00, CRC8_INIT};
    else if (step) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/amr_readout.sv
module amr_readout #(
  parameter int WIN_BITS = 256,
  localparam int LEN_W = $clog2(WIN_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [WIN_BITS-1:0] load_data,
  input  logic [LEN_W-1:0]    load_len,
  input  logic                host_clk,
  output logic                data_ready,
  output logic                data_out,
  output logic                host_rise
);
  logic [2:0]          sync_q;
  logic [WIN_BITS-1:0] sr_q;
  logic [LEN_W-1:0]    left_q;

  assign host_rise = sync_q[1] & ~sync_q[2];
  assign data_out  = data_ready & sr_q[WIN_BITS-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], host_clk};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q       <= '0;
      left_q     <= '0;
      data_ready <= 1'b0;
    end else if (load) begin
      sr_q       <= load_data;
      left_q     <= load_len;
      data_ready <= 1'b1;
    end else if (host_rise && data_ready) begin
      sr_q   <= {sr_q[WIN_BITS-2:0], 1'b0};
      left_q <= left_q - LEN_W'(1);
      if (left_q == LEN_W'(1)) data_ready <= 1'b0;
    end
  end
endmodule

// File: rtl/addr_match_rx.sv
module addr_match_rx
  import amr_pkg::*;
#(
  parameter int WIN_BITS = 256,
  parameter int ADDR_MAX = 40,
  localparam int LEN_W = $clog2(WIN_BITS + 1),
  localparam int AW    = $clog2(ADDR_MAX + 1),
  localparam int IW    = $clog2(WIN_BITS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic                in_bit,
  output logic                in_ready,
  input  logic [ADDR_MAX-1:0] cfg_own_addr,
  input  logic [AW-1:0]       cfg_addr_len,
  input  logic [LEN_W:0]      cfg_pkt_len,
  input  logic                cfg_crc_en,
  input  logic                cfg_crc_wide,
  input  logic                host_clk,
  output logic                data_ready,
  output logic                data_out,
  output logic                overflow
);
  amr_state_e state_q;
  logic [LEN_W-1:0] step_q;

  logic [LEN_W-1:0] p_eff, n_eff, crc_len, dat_len, pay_len, shamt;
  logic             cfg_ok, accept, hit_nxt, match_now, last_step;
  logic [WIN_BITS-1:0] win_q, win_nxt, dsrc, load_data;
  logic [LEN_W-1:0] fill_nxt;
  logic             crc_init, crc_step, crc_bit, deliver, load, ovf_q;
  logic [15:0]      crc_nxt, rx_crc;
  logic             host_rise;

  // Effective configuration
  assign p_eff   = (cfg_pkt_len > (LEN_W+1)'(WIN_BITS)) ? LEN_W'(WIN_BITS)
                                                      : cfg_pkt_len[LEN_W-1:0];
  assign n_eff   = (int'(cfg_addr_len) > ADDR_MAX) ? LEN_W'(ADDR_MAX) : LEN_W'(cfg_addr_len);
  assign crc_len = !cfg_crc_en ? '0 : (cfg_crc_wide ? LEN_W'(16) : LEN_W'(8));
  assign dat_len = p_eff - crc_len;
  assign pay_len = dat_len - n_eff;
  assign cfg_ok  = (n_eff != '0) && (p_eff > n_eff + crc_len);
  assign shamt   = LEN_W'(WIN_BITS) - (p_eff - n_eff);

  assign in_ready = (state_q == ST_SEARCH);
  assign accept   = in_valid & in_ready;

  amr_window #(.WIN_BITS(WIN_BITS)) u_win (
    .clk(clk), .rst_n(rst_n), .shift_en(accept), .bit_in(in_bit),
    .win_q(win_q), .win_nxt(win_nxt), .fill_nxt(fill_nxt)
  );

  // The search looks at the window as it will be after the incoming bit.
  amr_addr_cmp #(.WIN_BITS(WIN_BITS), .ADDR_MAX(ADDR_MAX)) u_cmp (
    .win(win_nxt), .pkt_len(p_eff), .addr_len(cfg_addr_len > AW'(ADDR_MAX) ? AW'(ADDR_MAX) : cfg_addr_len),
    .own_addr(cfg_own_addr), .hit(hit_nxt)
  );

  assign match_now = accept && cfg_ok && (fill_nxt >= p_eff) && hit_nxt;
  assign last_step = (step_q == dat_len - LEN_W'(1));
  assign crc_bit   = win_q[IW'(int'(p_eff) - 1 - int'(step_q))];
  assign rx_crc    = cfg_crc_wide ? win_q[15:0] : {8'h00, win_q[7:0]};

  amr_crc_unit u_crc (
    .clk(clk), .rst_n(rst_n), .init(crc_init), .step(crc_step),
    .bit_in(crc_bit), .wide(cfg_crc_wide), .crc_nxt(crc_nxt)
  );

  always_comb begin
    crc_init = 1'b0;
    crc_step = 1'b0;
    deliver  = 1'b0;
    unique case (state_q)
      ST_SEARCH: begin
        if (match_now) begin
          if (cfg_crc_en) crc_init = 1'b1;
          else            deliver  = 1'b1;
        end
      end
      ST_CHECK: begin
        crc_step = 1'b1;
        if (last_step && crc_nxt == rx_crc) deliver = 1'b1;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_SEARCH;
      step_q  <= '0;
    end else begin
      unique case (state_q)
        ST_SEARCH: begin
          step_q <= '0;
          if (match_now && cfg_crc_en) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          step_q <= step_q + LEN_W'(1);
          if (last_step) state_q <= ST_SEARCH;
        end
        default: state_q <= ST_SEARCH;
      endcase
    end
  end

  // Payload extraction: align the first payload bit with the register MSB.
  assign dsrc      = (state_q == ST_CHECK) ? win_q : win_nxt;
  assign load_data = dsrc << shamt;
  assign load      = deliver & ~data_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= deliver & data_ready;
  end
  assign overflow = ovf_q;

  amr_readout #(.WIN_BITS(WIN_BITS)) u_out (
    .clk(clk), .rst_n(rst_n), .load(load), .load_data(load_data),
    .load_len(pay_len), .host_clk(host_clk), .data_ready(data_ready),
    .data_out(data_out), .host_rise(host_rise)
  );
endmodule

// File: rtl/amr_chk.sv
module amr_chk #(
  parameter int WIN_BITS = 256,
  localparam int GW = $clog2(WIN_BITS + 1) + 1
) (
  input logic clk,
  input logic rst_n,
  input logic in_ready,
  input logic data_ready,
  input logic data_out,
  input logic overflow,
  input logic host_rise
);
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      gap_q <= '0;
    else if (in_ready)               gap_q <= '0;
    else if (gap_q != {GW{1'b1}})    gap_q <= gap_q + GW'(1);
  end

  // R8: no payload bit shown while nothing is held
  a_r8_quiet_out: assert property (@(posedge clk) disable iff (!rst_n)
    !data_ready |-> !data_out);

  // R8: data_ready only falls after a synchronised host edge
  a_r8_fall_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(data_ready) |-> $past(host_rise));

  // R9: a drop is only reported while a payload was held
  a_r9_ovf_needs_held: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> $past(data_ready));

  // R12: delivery leaves the engine ready for input
  a_r12_ready_on_deliver: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(data_ready) |-> in_ready);

  // R12: a CRC stall never outlasts a full window
  a_r12_stall_bounded: assert property (@(posedge clk) disable iff (!rst_n)
    gap_q <= GW'(WIN_BITS));
endmodule

bind addr_match_rx amr_chk #(.WIN_BITS(WIN_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .data_ready(data_ready),
  .data_out(data_out), .overflow(overflow), .host_rise(host_rise)
);

// File: tb/addr_match_rx_tb_top.sv
module addr_match_rx_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_bit = 1'b0, in_ready;
  logic [39:0] cfg_own_addr = '0;
  logic [5:0]  cfg_addr_len = 6'd8;
  logic [9:0]  cfg_pkt_len = 10'd32;
  logic cfg_crc_en = 1'b0, cfg_crc_wide = 1'b0;
  logic host_clk = 1'b0;
  logic data_ready, data_out, overflow;

  always #4 clk = ~clk;  // 125 MHz

  addr_match_rx dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_bit(in_bit), .in_ready(in_ready),
    .cfg_own_addr(cfg_own_addr), .cfg_addr_len(cfg_addr_len), .cfg_pkt_len(cfg_pkt_len),
    .cfg_crc_en(cfg_crc_en), .cfg_crc_wide(cfg_crc_wide), .host_clk(host_clk),
    .data_ready(data_ready), .data_out(data_out), .overflow(overflow)
  );

  typedef struct packed {
    logic [5:0]  n;
    logic [39:0] addr;
    logic [6:0]  l;
    logic [63:0] pay;
    logic [1:0]  mode;   // 0 none, 1 crc8, 2 crc16
    logic [1:0]  bad;    // 0 clean, 1 payload bit flipped, 2 address bit flipped
    logic [4:0]  junk;
    logic        exp;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{6'd8,  40'hE1,         7'd16, 64'hA5C3,     2'd2, 2'd0, 5'd5, 1'b1},
    '{6'd8,  40'hE1,         7'd16, 64'hA5C3,     2'd2, 2'd1, 5'd3, 1'b0},
    '{6'd16, 40'h9ABC,       7'd8,  64'h3C,       2'd1, 2'd0, 5'd7, 1'b1},
    '{6'd12, 40'hB0F,        7'd12, 64'h5A6,      2'd0, 2'd0, 5'd4, 1'b1},
    '{6'd40, 40'hF123456789, 7'd32, 64'hDEADBEEF, 2'd2, 2'd0, 5'd2, 1'b1},
    '{6'd12, 40'hB0F,        7'd12, 64'h5A6,      2'd0, 2'd2, 5'd4, 1'b0},
    '{6'd16, 40'h9ABC,       7'd8,  64'h3C,       2'd1, 2'd1, 5'd1, 1'b0}
  };

  int n_chk = 0, n_fail = 0, ovf_seen = 0;
  logic pk [0:299];
  int pk_n;

  always @(negedge clk) if (rst_n && overflow) ovf_seen <= ovf_seen + 1;

  function automatic string req_of(int v);
    case (v)
      0: return "R4";  1: return "R5";  2: return "R6";  3: return "R7";
      4: return "R11"; 5: return "R11"; default: return "R6";
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input logic [255:0] act,
                     input logic [255:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; host_clk = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic configure(input int n, input logic [39:0] a, input int p, input int mode);
    cfg_addr_len = 6'(n); cfg_own_addr = a; cfg_pkt_len = 10'(p);
    cfg_crc_en = (mode != 0); cfg_crc_wide = (mode == 2);
  endtask

  // Packet image: address MSB first, payload MSB first, CRC MSB first
  task automatic build(input int n, input logic [39:0] a, input int l,
                       input logic [255:0] pv, input int mode, input int bad);
    logic [15:0] c;
    logic fb;
    int cb;
    pk_n = 0;
    for (int i = 0; i < n; i++) begin pk[pk_n] = a[n-1-i]; pk_n++; end
    for (int j = 0; j < l; j++) begin pk[pk_n] = pv[l-1-j]; pk_n++; end
    cb = (mode == 2) ? 16 : (mode == 1) ? 8 : 0;
    c = (mode == 2) ? 16'hFFFF : 16'h00FF;
    for (int k = 0; k < n + l; k++) begin
      if (mode == 2) begin
        fb = c[15] ^ pk[k]; c = {c[14:0], 1'b0}; if (fb) c = c ^ 16'h1021;
      end else begin
        fb = c[7] ^ pk[k]; c = {8'h00, c[6:0], 1'b0}; if (fb) c = c ^ 16'h0007;
      end
    end
    for (int k = cb - 1; k >= 0; k--) begin pk[pk_n] = c[k]; pk_n++; end
    if (bad == 1) pk[n] = ~pk[n];
    if (bad == 2) pk[n-1] = ~pk[n-1];
  endtask

  task automatic send_bit(input logic b);
    in_valid = 1'b1; in_bit = b;
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_junk(input int cnt);
    for (int i = 0; i < cnt; i++) send_bit(1'b0);
  endtask

  task automatic send_packet();
    for (int i = 0; i < pk_n; i++) send_bit(pk[i]);
  endtask

  task automatic wait_ready(input int maxc, output bit got);
    got = 1'b0;
    for (int i = 0; i < maxc; i++) begin
      if (data_ready) begin got = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  task automatic read_payload(input int len, input logic [255:0] expv, input string req);
    logic [255:0] got;
    bit early;
    got = '0; early = 1'b0;
    for (int j = 0; j < len; j++) begin
      if (!data_ready) early = 1'b1;
      got[len-1-j] = data_out;
      host_clk = 1'b1; repeat (4) @(negedge clk);
      host_clk = 1'b0; repeat (4) @(negedge clk);
    end
    chk(got == expv, {req, " R2 payload bits in order"}, got, expv);
    chk(!early, "R8 data_ready held until last edge", 256'(early), 256'(0));
    chk(!data_ready, "R8 data_ready falls after last edge", 256'(data_ready), 256'(0));
    chk(!data_out, "R8 data_out quiet when empty", 256'(data_out), 256'(0));
  endtask

  task automatic run_tests();
    bit got;
    int p, cb, stall;
    logic [255:0] pv;

    // R1: reset state
    do_reset();
    chk(in_ready && !data_ready && !data_out && !overflow, "R1 reset outputs",
        256'({in_ready, data_ready, data_out, overflow}), 256'(4'b1000));

    // Vector table: R3 junk prefix, R4/R6 CRC modes, R5 bad CRC, R7 no CRC, R11 address
    for (int v = 0; v < 7; v++) begin
      do_reset();
      cb = (VECS[v].mode == 2) ? 16 : (VECS[v].mode == 1) ? 8 : 0;
      p = int'(VECS[v].n) + int'(VECS[v].l) + cb;
      configure(int'(VECS[v].n), VECS[v].addr, p, int'(VECS[v].mode));
      build(int'(VECS[v].n), VECS[v].addr, int'(VECS[v].l), 256'(VECS[v].pay),
            int'(VECS[v].mode), int'(VECS[v].bad));
      send_junk(int'(VECS[v].junk));
      send_packet();
      if (VECS[v].exp) begin
        if (VECS[v].mode != 0) begin
          // R12: stalled for P minus CRC length cycles
          chk(!in_ready, "R12 stall starts after last bit", 256'(in_ready), 256'(0));
          stall = 0;
          while (!in_ready && stall < 400) begin @(negedge clk); stall++; end
          chk(stall == p - cb, "R12 stall length", 256'(stall), 256'(p - cb));
        end else begin
          chk(in_ready && data_ready, "R7 R12 no stall and immediate delivery",
              256'({in_ready, data_ready}), 256'(2'b11));
        end
        wait_ready(10, got);
        chk(got, {req_of(v), " R3 packet after junk delivered"}, 256'(got), 256'(1));
        if (got) read_payload(int'(VECS[v].l), 256'(VECS[v].pay), req_of(v));
      end else begin
        repeat (p + 20) @(negedge clk);
        chk(!data_ready && in_ready, {req_of(v), " rejected packet not delivered"},
            256'({data_ready, in_ready}), 256'(2'b01));
      end
    end

    // R5: a failing packet followed directly by a good one
    do_reset();
    configure(8, 40'hE1, 40, 2);
    build(8, 40'hE1, 16, 256'h0F0F, 2, 1);
    send_junk(3);
    send_packet();
    build(8, 40'hE1, 16, 256'h1234, 2, 0);
    send_packet();
    wait_ready(60, got);
    chk(got, "R5 search resumes after CRC failure", 256'(got), 256'(1));
    if (got) read_payload(16, 256'h1234, "R5");

    // R9: second packet while the first is held
    do_reset();
    configure(8, 40'hE1, 16, 0);
    build(8, 40'hE1, 8, 256'h55, 0, 0);
    send_packet();
    chk(data_ready, "R9 first packet held", 256'(data_ready), 256'(1));
    ovf_seen = 0;
    build(8, 40'hE1, 8, 256'h0F, 0, 0);
    send_junk(4);
    send_packet();
    repeat (3) @(negedge clk);
    chk(ovf_seen == 1, "R9 overflow pulses once", 256'(ovf_seen), 256'(1));
    chk(!overflow, "R9 overflow is a pulse", 256'(overflow), 256'(0));
    read_payload(8, 256'h55, "R9");

    // R10: oversize length clamped to 256
    do_reset();
    configure(8, 40'hE1, 300, 0);
    pv = '0;
    for (int j = 0; j < 248; j++) pv[247-j] = (j % 3 == 0);
    build(8, 40'hE1, 248, pv, 0, 0);
    send_packet();
    wait_ready(5, got);
    chk(got, "R10 clamped packet delivered", 256'(got), 256'(1));
    if (got) read_payload(248, pv, "R10");
  endtask

  initial begin
    bit timed_out;
    timed_out = 1'b0;
    fork
      run_tests();
      begin repeat (150000) @(posedge clk); timed_out = 1'b1; end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=expired expected=finished");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule